// File: doc/BRIEF.md
# Multiplexed bus cycle sequencer

This block runs the external bus cycles of a processor that is the only master on its bus, where one set of pins carries first the address and then the data of each transfer. A caller presents a request (read or write, memory or I/O space, a 20-bit byte address, a byte/word flag and 16 bits of write data). The block steps through four bus states T1 to T4 and stretches the cycle with wait states for as long as the target keeps its ready line low.

Each bus state lasts two clocks: a first half and a second half. The half-cycle split gives the "late in T2" point where the read strobe asserts after the bus has floated, and the "middle of T4" point where the write strobe and write data are withdrawn. The block drives the address strobe, the space select, the read and write strobes, the transceiver direction and enable lines, the high-byte enable, and the shared bus with its output enable. It captures read data on entry to T4 and pulses a completion flag in the last clock of the cycle. External address latches and data transceivers are expected downstream; the bench models both.

Top module: `mux_bus_seq`

## Requirements
- R1: A request is accepted only on a clock edge where `req_ready` is high, and `req_ready` is high exactly while no cycle is in progress. A `req_valid` raised during a cycle is ignored: it changes neither the address of that cycle nor starts a new cycle when the current one ends.
- R2: `ale` is high for the first clock of a cycle only (first half of T1). The address is driven with `ad_oe` high for both clocks of T1, so it is stable when `ale` falls. A latch capturing on the falling edge of `ale` holds the requested address.
- R3: Byte selection on the bus (bus bit 0, `bhe_n`). A byte at an even address gives 0 and 1. A byte at an odd address gives 1 and 0. A word gives 0 and 0, and bit 0 of the requested address is then ignored. `bhe_n` keeps its value for the whole cycle.
- R4: `m_io` (1 = memory, 0 = I/O) and `dt_r` (1 = write, 0 = read) hold one value from T1 through T4. Both are 0 when idle.
- R5: In a read, `ad_oe` is low from the start of T2. `rd_n` goes low one clock later (second half of T2) and returns high at the middle of T4.
- R6: In a write, `wr_n` goes low at the start of T2. The write data is driven on bus bits 15:0 (bits 19:16 zero) with `ad_oe` high from the start of T2 until the middle of T4, when both are withdrawn.
- R7: `den_n` is low exactly while `rd_n` or `wr_n` is low.
- R8: `ready` is sampled at the end of T3 and at the end of each wait state. While it is low, wait states of two clocks each are inserted. With n wait states, a cycle occupies 8 + 2n clocks.
- R9: `rdata` takes the bus value present at the last edge of T3 or of the final wait state. It keeps that value through later write cycles until the next read.
- R10: `done` is high for exactly one clock, the last clock of the cycle (second half of T4). The block is idle on the following clock.
- R11: While idle, and after reset, `ale` and `ad_oe` are low, `rd_n`, `wr_n`, `den_n` and `bhe_n` are high, and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = single byte |
| req_wdata | input | 16 | Write data, lane-aligned |
| req_ready | output | 1 | Idle, a request can be taken |
| ready | input | 1 | Target ready, sampled at end of T3 and of wait states |
| ad_in | input | 16 | Data read from the shared bus |
| ad_out | output | 20 | Value driven onto the shared bus |
| ad_oe | output | 1 | Shared bus output enable |
| ale | output | 1 | Address strobe, latch on falling edge |
| m_io | output | 1 | Space select, 1 = memory |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dt_r | output | 1 | Transceiver direction, 1 = toward target |
| den_n | output | 1 | Transceiver enable, active low |
| bhe_n | output | 1 | High byte enable, active low |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-clock completion pulse |

## Verification
The assertions check on every cycle the relations between strobes: the bus is stable when the address strobe falls, the read strobe never overlaps a driven bus and follows a floated clock, the two strobes never overlap, the transceiver enable tracks the strobes, the space and direction lines stay fixed within a cycle, and the completion pulse is one clock wide. Only the bench's scenarios can show the exact clock at which each edge lands for a given number of wait states, the byte-lane encoding, the values held by the modelled address latch and transceiver path, and that requests raised mid-cycle and write cycles leave the captured read data and the running cycle alone.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T3   = 3'd3,
    S_TW   = 3'd4,
    S_T4   = 3'd5
  } tstate_e;

  typedef struct packed {
    logic ale;
    logic drive_addr;
    logic drive_data;
    logic rd;
    logic wr;
    logic den;
  } strobe_s;

endpackage

// File: rtl/mbs_tstate.sv
module mbs_tstate
  import mbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    ready,
  output tstate_e state,
  output logic    ph,
  output logic    cap_en,
  output logic    done
);

  tstate_e state_nxt;
  logic    ph_nxt;
  logic    adv_en;

  // state advances only while a cycle is running or one is starting
  assign adv_en = (state != S_IDLE) || start;

  always_comb begin
    state_nxt = state;
    ph_nxt    = ph;
    if (state == S_IDLE) begin
      ph_nxt = 1'b0;
      if (start) state_nxt = S_T1;
    end else begin
      ph_nxt = ~ph;
      if (ph) begin
        unique case (state)
          S_T1:       state_nxt = S_T2;
          S_T2:       state_nxt = S_T3;
          S_T3, S_TW: state_nxt = ready ? S_T4 : S_TW;
          S_T4:       state_nxt = S_IDLE;
          default:    state_nxt = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ph    <= 1'b0;
    end else if (adv_en) begin
      state <= state_nxt;
      ph    <= ph_nxt;
    end
  end

  assign cap_en = ((state == S_T3) || (state == S_TW)) && ph && ready;
  assign done   = (state == S_T4) && ph;

endmodule

// File: rtl/mbs_strobes.sv
module mbs_strobes
  import mbs_pkg::*;
(
  input  tstate_e state,
  input  logic    ph,
  input  logic    write,
  output strobe_s stb
);

  logic in_t1, in_t2, in_mid, in_t4a, body;

  always_comb begin
    in_t1  = (state == S_T1);
    in_t2  = (state == S_T2);
    in_mid = (state == S_T3) || (state == S_TW);
    in_t4a = (state == S_T4) && !ph;
    body   = in_t2 || in_mid || in_t4a;

    stb.ale        = in_t1 && !ph;
    stb.drive_addr = in_t1;
    stb.drive_data = write && body;
    stb.rd         = !write && ((in_t2 && ph) || in_mid || in_t4a);
    stb.wr         = write && body;
    stb.den        = (in_t2 && (write || ph)) || in_mid || in_t4a;
  end

endmodule

// File: rtl/mbs_reqreg.sv
module mbs_reqreg #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cap_en,
  input  logic              in_write,
  input  logic              in_mem,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_word,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic              r_write,
  output logic              r_mem,
  output logic [ADDR_W-1:0] r_addr,
  output logic              r_word,
  output logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_write <= 1'b0;
      r_mem   <= 1'b0;
      r_addr  <= '0;
      r_word  <= 1'b0;
      r_wdata <= '0;
    end else if (load) begin
      r_write <= in_write;
      r_mem   <= in_mem;
      r_addr  <= in_addr;
      r_word  <= in_word;
      r_wdata <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en && !r_write) begin
      rdata <= bus_in;
    end
  end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              ready,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              m_io,
  output logic              rd_n,
  output logic              wr_n,
  output logic              dt_r,
  output logic              den_n,
  output logic              bhe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  localparam int HI_W = ADDR_W - DATA_W;

  tstate_e           state;
  logic              ph, cap_en, start, active, a0;
  strobe_s           stb;
  logic              r_write, r_mem, r_word;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;

  assign req_ready = (state == S_IDLE);
  assign start     = req_valid && req_ready;
  assign active    = !req_ready;

  mbs_tstate u_tstate (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .ready  (ready),
    .state  (state),
    .ph     (ph),
    .cap_en (cap_en),
    .done   (done)
  );

  mbs_reqreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reqreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .cap_en   (cap_en),
    .in_write (req_write),
    .in_mem   (req_mem),
    .in_addr  (req_addr),
    .in_word  (req_word),
    .in_wdata (req_wdata),
    .bus_in   (ad_in),
    .r_write  (r_write),
    .r_mem    (r_mem),
    .r_addr   (r_addr),
    .r_word   (r_word),
    .r_wdata  (r_wdata),
    .rdata    (rdata)
  );

  mbs_strobes u_strobes (
    .state (state),
    .ph    (ph),
    .write (r_write),
    .stb   (stb)
  );

  // word transfers always start on the even byte
  assign a0 = r_addr[0] && !r_word;

  always_comb begin
    ad_out = '0;
    if (stb.drive_addr) begin
      ad_out = {r_addr[ADDR_W-1:1], a0};
    end else if (stb.drive_data) begin
      ad_out = {{HI_W{1'b0}}, r_wdata};
    end
  end

  assign ad_oe = stb.drive_addr || stb.drive_data;
  assign ale   = stb.ale;
  assign rd_n  = !stb.rd;
  assign wr_n  = !stb.wr;
  assign den_n = !stb.den;
  assign m_io  = active && r_mem;
  assign dt_r  = active && r_write;
  assign bhe_n = !(active && (r_word || r_addr[0]));

endmodule

module mux_bus_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] ad_out,
  input logic              ad_oe,
  input logic              ale,
  input logic              m_io,
  input logic              rd_n,
  input logic              wr_n,
  input logic              dt_r,
  input logic              den_n,
  input logic              bhe_n,
  input logic              done
);

  // R2
  ale_fall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ad_oe && $stable(ad_out));

  // R3
  byte_sel_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !(bhe_n && ad_out[0]));

  // R4
  space_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(m_io) && $stable(dt_r) && $stable(bhe_n));

  // R5
  read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R5
  read_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(!ad_oe) && $past(!req_ready));

  // R6
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe && rd_n);

  // R7
  den_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n) == (!rd_n || !wr_n));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ale && !ad_oe && rd_n && wr_n && den_n && bhe_n && !done);

endmodule

bind mux_bus_seq mux_bus_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, req_mem, req_word;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready;
  logic        ready;
  logic [15:0] ad_in;
  logic [19:0] ad_out;
  logic        ad_oe, ale, m_io, rd_n, wr_n, dt_r, den_n, bhe_n, done;
  logic [15:0] rdata;

  int checks = 0;
  int fails  = 0;

  // downstream models: address latch and target side of the transceivers
  logic [19:0] lat_addr;
  logic [15:0] tgt_wdata;
  logic [15:0] last_rd;

  mux_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mem(req_mem), .req_addr(req_addr), .req_word(req_word),
    .req_wdata(req_wdata), .req_ready(req_ready), .ready(ready), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .m_io(m_io), .rd_n(rd_n),
    .wr_n(wr_n), .dt_r(dt_r), .den_n(den_n), .bhe_n(bhe_n), .rdata(rdata),
    .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge ale) lat_addr <= ad_out;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_addr(input logic [19:0] a, input logic w);
    return {a[19:1], a[0] & ~w};
  endfunction

  function automatic logic exp_bhe_n(input logic [19:0] a, input logic w);
    return ~(w | a[0]);
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " R11 ale"}, ale, 0);
    chk({tag, " R11 oe"}, ad_oe, 0);
    chk({tag, " R11 strobes"}, {rd_n, wr_n, den_n, bhe_n}, 4'hF);
    chk({tag, " R11 done"}, done, 0);
    chk({tag, " R4 idle space/dir"}, {m_io, dt_r}, 0);
    chk({tag, " R1 req_ready"}, req_ready, 1);
  endtask

  task automatic run_cycle(input logic w, input logic mem, input logic [19:0] a,
                           input logic word, input logic [15:0] wd,
                           input int n, input logic [15:0] rv, input bit poke);
    int L;
    logic in_data;
    L = 8 + 2 * n;
    @(negedge clk);
    chk("R1 ready before request", req_ready, 1);
    req_valid = 1; req_write = w; req_mem = mem; req_addr = a;
    req_word = word; req_wdata = wd; ready = 0;
    tgt_wdata = 16'h0;
    @(negedge clk);
    req_valid = 0;
    req_addr = ~a; req_write = ~w; req_wdata = ~wd;
    for (int k = 1; k <= L; k++) begin
      in_data = (k >= 3) && (k <= L - 1);
      chk("R2 ale", ale, k == 1);
      chk("R1 busy", req_ready, 0);
      chk("R4 m_io", m_io, mem);
      chk("R4 dt_r", dt_r, w);
      chk("R3 bhe_n", bhe_n, exp_bhe_n(a, word));
      chk("R5 rd_n", rd_n, !(!w && k >= 4 && k <= L - 1));
      chk("R6 wr_n", wr_n, !(w && in_data));
      chk("R7 den_n", den_n, !(w ? in_data : (k >= 4 && k <= L - 1)));
      chk("R5 R6 ad_oe", ad_oe, (k <= 2) || (w && in_data));
      chk("R8 R10 done", done, k == L);
      if (k <= 2) chk("R2 R3 address", ad_out, exp_addr(a, word));
      else if (w && in_data) chk("R6 write data", ad_out, {4'h0, wd});
      if (!wr_n && !den_n && dt_r) tgt_wdata = ad_out[15:0];
      ready = (k >= 6 + 2 * n);
      ad_in = !rd_n ? rv : (16'hA5C3 ^ 16'(k));
      req_valid = poke && (k == 3);
      if (k < L) @(negedge clk);
    end
    req_valid = 0;
    @(negedge clk);
    check_idle("after cycle");
    chk("R2 latched address", lat_addr, exp_addr(a, word));
    if (w) begin
      chk("R6 target saw write data", tgt_wdata, wd);
      chk("R9 rdata kept over write", rdata, last_rd);
    end else begin
      last_rd = rv;
      chk("R9 rdata captured", rdata, rv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    rst_n = 0; req_valid = 0; req_write = 0; req_mem = 0; req_addr = '0;
    req_word = 0; req_wdata = '0; ready = 0; ad_in = '0; last_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_idle("reset");
    chk("R9 reset rdata", rdata, 0);

    // directed corner cases
    run_cycle(0, 1, 20'h12344, 1, 16'h0, 0, 16'hBEEF, 0);   // R3 word, R8 no waits
    run_cycle(0, 0, 20'h00021, 0, 16'h0, 3, 16'h1234, 0);   // R3 odd byte, R8 waits
    run_cycle(1, 1, 20'hFFFF0, 0, 16'h00AB, 0, 16'h0, 1);   // R1 poke, R3 even byte
    run_cycle(1, 0, 20'h0ABC7, 1, 16'hCAFE, 5, 16'h0, 0);   // R3 word ignores bit 0
    run_cycle(0, 1, 20'h55555, 0, 16'h0, 1, 16'h8001, 1);   // R1 poke during read

    // random mix
    for (int i = 0; i < 40; i++) begin
      run_cycle(1'($urandom), 1'($urandom), 20'($urandom), 1'($urandom),
                16'($urandom), int'($urandom % 4), 16'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule